// File: doc/BRIEF.md
# Dithered Phase-Accumulator Cosine Oscillator

This block is a numerically controlled oscillator that produces a signed 16-bit cosine carrier, one sample per clock. A 32-bit phase register advances by a software-supplied tuning word each cycle and wraps modulo 2^32. The top 13 bits of the phase are mapped to an amplitude through a quarter-wave magnitude table, with per-quadrant address mirroring and sign flipping. For example, a 100 MHz sample clock with a 750 kHz carrier uses a tuning word of 32212255.

Cutting the phase to 13 bits creates periodic spurs. To break them up, an optional pseudo-random offset can be added to the full-width phase before it is cut. The offset comes from a 32-bit maximal-length shift register, and a level input selects how many of its low bits are kept.

The output is a continuous stream with a valid flag and no ready input. Once valid rises it stays high until the next reset, and the block never waits. A consumer must take a sample on every clock in which valid is high, or drop it.

Top module: `phase_cos_nco`

## Requirements
- R1: The phase register starts at 0 after reset. On each clock out of reset it becomes (phase + tune_word) mod 2^32, so tuning words above 2^31 or near 2^32 wrap without error.
- R2: For a 13-bit phase index p (phase bits 31:19), let M(k) = round(32767·cos(2πk/8192)) for k in 0..2048. The output is:
  - M(p) when p ≤ 2048;
  - −M(4096−p) when 2048 < p ≤ 4096;
  - −M(p−4096) when 4096 < p < 6144;
  - M(8192−p) otherwise.
  Bits 12:11 of p are the quadrant, and the output never reaches −32768.
- R3: Latency timing:
  - During reset, cos_out is 0 and cos_valid is 0.
  - cos_valid stays 0 after the first clock out of reset and is 1 from the second clock on.
  - The sample shown after clock n belongs to the phase held before clock n−1.
- R4: With dith_en = 0, the output is bit-exact to R2 for the undithered phase, whatever the value of dith_lvl.
- R5: With dith_en = 1, each sample equals the R2 value either for index p or for index p+1 (mod 8192), where p is the undithered index.
- R6: With dith_en = 1 and dith_lvl = 0, the offset is empty and the output is bit-exact to R2.
- R7: Any dith_lvl above 19 acts as 19, so the offset is always below 2^19 (one phase-index step).
- R8: With dith_en = 1 and dith_lvl = 19, the offset changes from clock to clock, so that some samples take the p+1 value where it differs from the p value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_word | input | 32 | Phase increment per clock |
| dith_en | input | 1 | Adds the pseudo-random phase offset when 1 |
| dith_lvl | input | 5 | Number of low offset bits kept, clamped to 19 |
| cos_out | output | 16 | Signed two's-complement cosine sample |
| cos_valid | output | 1 | High while cos_out carries a sample |

## Verification
The hardest case to reach from the ports is a dithered sample landing on the next phase index. Neither the offset nor the undithered phase is visible, and near the cosine peak adjacent indices give the same value. The bench keeps its own copy of the phase and runs the carrier tuning word with the full dither level. Over two thousand samples the phase sweeps the steep parts of every quadrant. The bench then counts samples that match only the p+1 value, and a separate segment at level 31 shows that the offset never reaches two index steps.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int ACC_W  = 32;
  localparam int PH_W   = 13;
  localparam int OUT_W  = 16;
  localparam int LVL_W  = 5;
  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

  // Magnitude of the cosine at index k of a (1<<ph_w)-step circle, rounded.
  function automatic int unsigned quarter_mag(int unsigned k, int unsigned ph_w,
                                              int unsigned out_w);
    real amp;
    real ang;
    amp = real'((1 << (out_w - 1)) - 1);
    ang = 2.0 * 3.14159265358979323846 * real'(k) / real'(1 << ph_w);
    return $unsigned($rtoi(amp * $cos(ang) + 0.5));
  endfunction
endpackage

// File: rtl/osc_phase_acc.sv
module osc_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] tune,
  output logic [ACC_W-1:0] acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc + tune;
  end

  // R1: phase moves by exactly the previous tuning word, modulo the width
  p_acc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> acc == ACC_W'($past(acc) + $past(tune)));
endmodule

// File: rtl/osc_dither_gen.sv
module osc_dither_gen #(
  parameter int          ACC_W    = 32,
  parameter int          LVL_W    = 5,
  parameter int          MAX_BITS = 19,
  parameter logic [31:0] TAPS     = 32'h8020_0003
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LVL_W-1:0] lvl,
  output logic [ACC_W-1:0] dith
);
  logic [ACC_W-1:0] lfsr;
  logic [LVL_W-1:0] eff_lvl;
  logic [ACC_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lfsr <= ACC_W'(1);
    else if (lfsr[0]) lfsr <= (lfsr >> 1) ^ TAPS[ACC_W-1:0];
    else              lfsr <= lfsr >> 1;
  end

  always_comb begin
    eff_lvl = (lvl > LVL_W'(MAX_BITS)) ? LVL_W'(MAX_BITS) : lvl;
    mask    = ~({ACC_W{1'b1}} << eff_lvl);
    dith    = en ? (lfsr & mask) : '0;
  end

  // R8: the register never locks up in the all-zero state
  p_lfsr_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
  // R4: no offset leaves the generator while dither is off
  p_dither_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> dith == '0);
  // R7: the offset stays below one truncated phase step
  p_dither_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dith >> MAX_BITS) == '0);
endmodule

// File: rtl/osc_quarter_map.sv
module osc_quarter_map #(
  parameter int PH_W  = 13,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  phase,
  output logic [OUT_W-1:0] cos_q
);
  import osc_pkg::*;

  localparam int ADDR_W = PH_W - 2;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int MAG_W  = OUT_W - 1;

  logic [MAG_W-1:0]  rom [DEPTH];
  logic [1:0]        quad;
  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] addr;
  logic              at_null;
  logic              neg;
  logic [MAG_W-1:0]  mag;
  logic [OUT_W-1:0]  value;

  initial begin
    for (int i = 0; i < DEPTH; i++)
      rom[i] = MAG_W'(quarter_mag(i, PH_W, OUT_W));
  end

  always_comb begin
    quad    = phase[PH_W-1 -: 2];
    offs    = phase[ADDR_W-1:0];
    // odd quadrants read the table mirrored; their zero offset is the null
    addr    = quad[0] ? ((~offs) + ADDR_W'(1)) : offs;
    at_null = quad[0] && (offs == '0);
    neg     = quad[1] ^ quad[0];
    mag     = at_null ? '0 : rom[addr];
    value   = neg ? (OUT_W'(0) - {1'b0, mag}) : {1'b0, mag};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cos_q <= '0;
    else        cos_q <= value;
  end

  // R2: output never reaches the most negative code
  p_peak_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cos_q != {1'b1, {(OUT_W-1){1'b0}}});
  // R2: the third quadrant never produces a positive sample
  p_quadrant_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(phase[PH_W-1 -: 2]) == 2'b10) |-> $signed(cos_q) <= 0);
  // R2: the first quadrant never produces a negative sample
  p_first_quad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(phase[PH_W-1 -: 2]) == 2'b00) |-> !cos_q[OUT_W-1]);
endmodule

// File: rtl/phase_cos_nco.sv
module phase_cos_nco
  import osc_pkg::*;
#(
  parameter int ACC_BITS = osc_pkg::ACC_W,
  parameter int PH_BITS  = osc_pkg::PH_W,
  parameter int OUT_BITS = osc_pkg::OUT_W,
  parameter int LVL_BITS = osc_pkg::LVL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ACC_BITS-1:0] tune_word,
  input  logic                dith_en,
  input  logic [LVL_BITS-1:0] dith_lvl,
  output logic [OUT_BITS-1:0] cos_out,
  output logic                cos_valid
);
  localparam int TRUNC_W = ACC_BITS - PH_BITS;
  localparam int LAT     = 2;

  logic [ACC_BITS-1:0] acc;
  logic [ACC_BITS-1:0] dith;
  logic [ACC_BITS-1:0] sum;
  logic [PH_BITS-1:0]  phase_q;
  logic [LAT-1:0]      vld_sr;
  logic                unused_low;

  osc_phase_acc #(.ACC_W(ACC_BITS)) u_acc (
    .clk(clk), .rst_n(rst_n), .tune(tune_word), .acc(acc)
  );

  osc_dither_gen #(
    .ACC_W(ACC_BITS), .LVL_W(LVL_BITS), .MAX_BITS(TRUNC_W), .TAPS(LFSR_TAPS)
  ) u_dith (
    .clk(clk), .rst_n(rst_n), .en(dith_en), .lvl(dith_lvl), .dith(dith)
  );

  assign sum        = acc + dith;
  assign unused_low = ^sum[TRUNC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      vld_sr  <= '0;
    end else begin
      phase_q <= sum[ACC_BITS-1 -: PH_BITS];
      vld_sr  <= {vld_sr[LAT-2:0], 1'b1};
    end
  end

  osc_quarter_map #(.PH_W(PH_BITS), .OUT_W(OUT_BITS)) u_map (
    .clk(clk), .rst_n(rst_n), .phase(phase_q), .cos_q(cos_out)
  );

  assign cos_valid = vld_sr[LAT-1];

  // R3: once the stream starts it does not stop before reset
  p_valid_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cos_valid |=> cos_valid);
  // R3: valid is never seen in the first clock out of reset
  p_valid_late_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cos_valid |-> $past(rst_n));
endmodule

// File: tb/sim_phase_cos_nco.sv
module sim_phase_cos_nco;
  typedef struct {
    int unsigned ph;
    bit          dith;
    string       tag;
  } item_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] tune_word = 0;
  logic        dith_en = 0;
  logic [4:0]  dith_lvl = 0;
  logic [15:0] cos_out;
  logic        cos_valid;

  int    n_chk = 0;
  int    n_fail = 0;
  int    alt_hits = 0;
  string cur_tag = "R4";
  longint unsigned macc = 0;
  item_t sb[$];

  phase_cos_nco u0 (
    .clk(clk), .rst_n(rst_n), .tune_word(tune_word), .dith_en(dith_en),
    .dith_lvl(dith_lvl), .cos_out(cos_out), .cos_valid(cos_valid)
  );

  always #10 clk = ~clk;

  function automatic int mref(int unsigned k);
    real a;
    a = 32767.0 * $cos(2.0 * 3.14159265358979323846 * real'(k) / 8192.0);
    return $rtoi(a + 0.5);
  endfunction

  function automatic int fold(int unsigned p);
    if (p <= 2048)      return mref(p);
    else if (p <= 4096) return -mref(4096 - p);
    else if (p < 6144)  return -mref(p - 4096);
    else                return mref(8192 - p);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver side: model phase and push the expected item at every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      macc = 0;
      sb.delete();
    end else begin
      item_t it;
      it.ph   = int'(macc >> 19);
      it.dith = dith_en && (dith_lvl != 0);
      it.tag  = cur_tag;
      sb.push_back(it);
      macc = (macc + tune_word) & 64'hFFFF_FFFF;
    end
  end

  // monitor: compare each valid sample with the oldest expected item
  always @(negedge clk) begin
    #1;
    if (rst_n && cos_valid) begin
      if (sb.size() == 0) begin
        check(0, "R3 (no expected item)", $signed(cos_out), 0);
      end else begin
        item_t it;
        int e0, e1, act;
        it  = sb.pop_front();
        e0  = fold(it.ph);
        e1  = fold((it.ph + 1) % 8192);
        act = $signed(cos_out);
        if (it.dith && act == e1 && e0 != e1) alt_hits++;
        check(act == e0 || (it.dith && act == e1), it.tag, act, e0);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic run(logic [31:0] tw, logic en, logic [4:0] lvl, string tag, int n);
    tune_word = tw;
    dith_en   = en;
    dith_lvl  = lvl;
    cur_tag   = tag;
    repeat (n) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tune_word = 32'd32212255;
    dith_lvl  = 5'd7;
    repeat (3) step();
    // R3: reset state
    check(cos_valid == 0, "R3 valid in reset", cos_valid, 0);
    check(cos_out == 0, "R3 output in reset", $signed(cos_out), 0);
    rst_n = 1;
    step();
    check(cos_valid == 0, "R3 valid after first clock", cos_valid, 0);
    step();
    check(cos_valid == 1, "R3 valid after second clock", cos_valid, 1);

    // R4: carrier word, dither off, level ignored
    run(32'd32212255, 0, 5'd7, "R4 carrier no dither", 2000);
    run(32'd32212255, 0, 5'd19, "R4 level ignored when off", 500);
    // R2: quarter-turn steps hit peaks and nulls of every quadrant
    run(32'h4000_0000, 0, 0, "R2 quadrant points", 64);
    run(32'h0080_0000, 0, 0, "R2 coarse sweep", 512);
    run(32'h0007_FFFF, 0, 0, "R2 slow sweep", 600);
    // R1: wrapping words
    run(32'hFFFF_F000, 0, 0, "R1 near full-scale word", 300);
    run(32'h8000_0001, 0, 0, "R1 half-turn word", 300);
    run(32'h1234_5679, 0, 0, "R1 odd word", 400);
    // R6: dither on with empty mask
    run(32'd32212255, 1, 5'd0, "R6 level zero exact", 800);
    // R5/R8: full dither level
    alt_hits = 0;
    run(32'd32212255, 1, 5'd19, "R5 dither level 19", 2000);
    check(alt_hits > 0, "R8 dither reaches next index", alt_hits, 1);
    // R7: out-of-range level clamps
    run(32'h0123_4567, 1, 5'd31, "R7 level 31 clamped", 1500);
    run(32'd32212255, 1, 5'd25, "R7 level 25 clamped", 800);

    // R3: reset during the stream
    rst_n = 0;
    step();
    check(cos_valid == 0, "R3 valid drops in reset", cos_valid, 0);
    check(cos_out == 0, "R3 output clears in reset", $signed(cos_out), 0);
    rst_n = 1;
    step();
    check(cos_valid == 0, "R3 valid after first clock again", cos_valid, 0);
    run(32'h2000_0000, 0, 0, "R1 restart from zero phase", 200);
    check(cos_valid == 1, "R3 valid held", cos_valid, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule